// File: doc/BRIEF.md
# Transmit Link Startup Sequencer

This block sequences the start of the transmit side of a multi-lane serial converter link in the JESD204B style. It keeps a local multiframe counter that advances once per octet clock and wraps every multiframe. A one-cycle SYSREF strobe realigns the counter. When the receiver pulls its active-low SYNC request, the block asks the framing datapath for comma characters (K28.5). Once SYNC is released, the block waits for a multiframe boundary. It can then hold off for up to three extra multiframes. After that it requests a four-multiframe initial lane alignment sequence (ILA), and then switches to payload data, which can be scrambled.

For every octet the block gives the downstream framer and encoder a two-bit source select and a control-character flag. In the ILA, the flag marks the first and last octet of each multiframe, which are where the start and end markers go. A force control lets SYSREF load the counter with a programmable start value instead of zero. This shortens the first multiframe, so the ILA starts earlier. The encoder, the serializer and the ILA octet contents are outside this block.

Top module: `jesd_tx_link_seq`

## Requirements
- R1: After reset the octet select is 2'b00 (none), the control flag and scramble flag are 0, the counter is 0, and the machine stays idle while SYNC is held high.
- R2: The counter steps 0,1,…,31 and wraps to 0, one step per clock. A SYSREF strobe with force=0 loads 0 whatever the start value is.
- R3: A SYSREF strobe with force=1 loads the 5-bit start value, which takes effect in the next cycle.
- R4: SYNC low, sampled at a clock edge, puts the machine into code-group sync from any state. From the next cycle the select is 2'b01 (K28.5) and the control flag is 1.
- R5: With SYNC high, the octet at count 31 is the last K28.5 octet. With delay 0, the ILA starts at count 0. So after SYSREF loads start value S, exactly 32−S K28.5 octets come before the ILA.
- R6: A delay field value d (0 to 3) adds exactly 32·d more K28.5 octets before the ILA.
- R7: The ILA (select 2'b10) lasts exactly 4 multiframes (128 octets). The control flag is 1 only on the first and last octet of each multiframe, which gives 8 flagged octets.
- R8: After the ILA the select is 2'b11 (data) with the control flag at 0. The scramble flag equals the scramble enable in the data state and is 0 in every other state.
- R9: A SYSREF strobe while the link is running realigns the counter but does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sysref_i | input | 1 | One-cycle alignment strobe |
| sync_n_i | input | 1 | Receiver sync request, active low |
| force_start_i | input | 1 | 1: SYSREF loads start value instead of 0 |
| start_val_i | input | 5 | Counter value loaded by SYSREF when forced |
| ila_delay_i | input | 2 | Extra multiframes before the ILA (0 to 3) |
| scr_en_i | input | 1 | Scramble enable for payload |
| octet_sel_o | output | 2 | 00 none, 01 K28.5, 10 ILA, 11 data |
| ctrl_k_o | output | 1 | Octet is a control character |
| scramble_o | output | 1 | Payload octet goes through the scrambler |

## Verification
A SYSREF strobe or a SYNC change seen at an edge shows on the outputs from the cycle after that edge. The select and flags are decoded straight from registered state, so they are valid as soon as the state updates. The bench drives and samples two time units after each rising edge, and counts octets per output class from the first cycle after the SYSREF edge. A sweep over several start values and all four delays therefore compares the K28.5 run length (32−S+32·d), the ILA length and its flag count against closed-form values. Realign, forced-resync and idle cases are checked in the first cycle after their stimulus edge.

// File: rtl/jesd_seq_pkg.sv
package jesd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CGS      = 3'd1,
    ST_ILA_WAIT = 3'd2,
    ST_ILA      = 3'd3,
    ST_DATA     = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_K    = 2'b01,
    SEL_ILA  = 2'b10,
    SEL_DATA = 2'b11
  } octet_sel_e;

  // Value the multiframe counter takes after one octet clock.
  function automatic logic [7:0] lmfc_step(input logic [7:0] cnt, input logic [7:0] last);
    return (cnt == last) ? 8'd0 : cnt + 8'd1;
  endfunction

  // Value loaded by an alignment strobe.
  function automatic logic [7:0] lmfc_load(input logic force_en, input logic [7:0] start);
    return force_en ? start : 8'd0;
  endfunction

endpackage

// File: rtl/lmfc_counter.sv
module lmfc_counter
  import jesd_seq_pkg::*;
#(
  parameter int MF_OCTETS = 32,
  localparam int CNT_W = $clog2(MF_OCTETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysref_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             mf_end_o
);

  localparam logic [7:0] LAST = 8'(MF_OCTETS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (sysref_i) cnt_d = CNT_W'(lmfc_load(force_i, 8'(init_i)));
    else          cnt_d = CNT_W'(lmfc_step(8'(cnt_q), LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o    = cnt_q;
  assign mf_end_o = (8'(cnt_q) == LAST);

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_end_o && !sysref_i) |=> (cnt_q == '0));
  a_r2_unforced_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref_i && !force_i) |=> (cnt_q == '0));
  a_r3_forced_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref_i && force_i) |=> (cnt_q == $past(init_i)));

endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import jesd_seq_pkg::*;
#(
  parameter int ILA_MF = 4,
  parameter int DLY_W  = 2,
  localparam int ILA_W = (ILA_MF > 1) ? $clog2(ILA_MF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n_i,
  input  logic             mf_end_i,
  input  logic [DLY_W-1:0] dly_i,
  output seq_state_e       state_o
);

  seq_state_e       state_q, state_d;
  logic [DLY_W-1:0] wait_q, wait_d;
  logic [ILA_W-1:0] ila_mf_q, ila_mf_d;

  // Named events for the assertions.
  logic cgs_done, wait_done, ila_done;
  assign cgs_done  = (state_q == ST_CGS) && mf_end_i;
  assign wait_done = (state_q == ST_ILA_WAIT) && mf_end_i && (wait_q == DLY_W'(1));
  assign ila_done  = (state_q == ST_ILA) && mf_end_i && (ila_mf_q == ILA_W'(ILA_MF - 1));

  always_comb begin
    state_d  = state_q;
    wait_d   = wait_q;
    ila_mf_d = ila_mf_q;
    if (!sync_n_i) begin
      state_d = ST_CGS;
    end else begin
      case (state_q)
        ST_CGS: if (cgs_done) begin
          if (dly_i == '0) begin
            state_d  = ST_ILA;
            ila_mf_d = '0;
          end else begin
            state_d = ST_ILA_WAIT;
            wait_d  = dly_i;
          end
        end
        ST_ILA_WAIT: if (mf_end_i) begin
          if (wait_done) begin
            state_d  = ST_ILA;
            ila_mf_d = '0;
          end else begin
            wait_d = wait_q - DLY_W'(1);
          end
        end
        ST_ILA: if (mf_end_i) begin
          if (ila_done) state_d = ST_DATA;
          else          ila_mf_d = ila_mf_q + ILA_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      wait_q   <= '0;
      ila_mf_q <= '0;
    end else begin
      state_q  <= state_d;
      wait_q   <= wait_d;
      ila_mf_q <= ila_mf_d;
    end
  end

  assign state_o = state_q;

  a_r4_sync_forces_cgs: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_i |=> (state_q == ST_CGS));
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && sync_n_i) |=> (state_q == ST_IDLE));
  a_r6_wait_holds_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ILA_WAIT && sync_n_i && !mf_end_i) |=> (state_q == ST_ILA_WAIT));
  a_r7_data_after_ila: assert property (@(posedge clk) disable iff (!rst_n)
    (ila_done && sync_n_i) |=> (state_q == ST_DATA));

endmodule

// File: rtl/jesd_tx_link_seq.sv
module jesd_tx_link_seq
  import jesd_seq_pkg::*;
#(
  parameter int MF_OCTETS = 32,
  parameter int ILA_MF    = 4,
  parameter int DLY_W     = 2,
  localparam int CNT_W    = $clog2(MF_OCTETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysref_i,
  input  logic             sync_n_i,
  input  logic             force_start_i,
  input  logic [CNT_W-1:0] start_val_i,
  input  logic [DLY_W-1:0] ila_delay_i,
  input  logic             scr_en_i,
  output logic [1:0]       octet_sel_o,
  output logic             ctrl_k_o,
  output logic             scramble_o
);

  logic [CNT_W-1:0] lmfc_cnt;
  logic             mf_end;
  logic             mf_first;
  seq_state_e       state;
  octet_sel_e       sel;

  lmfc_counter #(.MF_OCTETS(MF_OCTETS)) u_lmfc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sysref_i (sysref_i),
    .force_i  (force_start_i),
    .init_i   (start_val_i),
    .cnt_o    (lmfc_cnt),
    .mf_end_o (mf_end)
  );

  link_fsm #(.ILA_MF(ILA_MF), .DLY_W(DLY_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_n_i (sync_n_i),
    .mf_end_i (mf_end),
    .dly_i    (ila_delay_i),
    .state_o  (state)
  );

  assign mf_first = (lmfc_cnt == '0);

  always_comb begin
    sel        = SEL_NONE;
    ctrl_k_o   = 1'b0;
    scramble_o = 1'b0;
    case (state)
      ST_CGS, ST_ILA_WAIT: begin
        sel      = SEL_K;
        ctrl_k_o = 1'b1;
      end
      ST_ILA: begin
        sel      = SEL_ILA;
        ctrl_k_o = mf_first || mf_end;
      end
      ST_DATA: begin
        sel        = SEL_DATA;
        scramble_o = scr_en_i;
      end
      default: ;
    endcase
  end

  assign octet_sel_o = sel;

  a_r8_scramble_in_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    scramble_o |-> (octet_sel_o == SEL_DATA));
  a_r8_no_ctrl_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (octet_sel_o == SEL_DATA) |-> !ctrl_k_o);
  a_r5_ila_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ILA && $past(state) != ST_ILA && !$past(sysref_i)) |-> mf_first);
  a_r9_realign_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sysref_i && sync_n_i && state == ST_DATA) |=> (state == ST_DATA));

endmodule

// File: tb/jesd_tx_link_seq_tb.sv
`timescale 1ns/1ps
module jesd_tx_link_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sysref = 1'b0;
  logic       sync_n = 1'b1;
  logic       force_st = 1'b0;
  logic [4:0] start_val = '0;
  logic [1:0] dly = '0;
  logic       scr_en = 1'b0;
  logic [1:0] sel;
  logic       ctrl_k;
  logic       scr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jesd_tx_link_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sysref_i(sysref), .sync_n_i(sync_n),
    .force_start_i(force_st), .start_val_i(start_val), .ila_delay_i(dly),
    .scr_en_i(scr_en), .octet_sel_o(sel), .ctrl_k_o(ctrl_k), .scramble_o(scr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // Aligns with start value s, releases SYNC, then measures the K28.5 run,
  // the ILA run and the data state.
  task automatic run_case(input bit frc, input int s, input int d, input bit se, input int exp_k);
    int nk, ni, nflag;
    bit first_flag;
    force_st = frc; start_val = 5'(s); dly = 2'(d); scr_en = se;
    sync_n = 1'b0;
    tick(); tick();
    sysref = 1'b1;
    tick();
    sysref = 1'b0;
    sync_n = 1'b1;
    nk = 0;
    while (sel == 2'b01 && nk < 1000) begin nk++; tick(); end
    check(d == 0 ? "R5 K28.5 run length" : "R6 delayed K28.5 run length", nk, exp_k);
    ni = 0; nflag = 0; first_flag = ctrl_k;
    while (sel == 2'b10 && ni < 1000) begin
      ni++;
      nflag += int'(ctrl_k);
      if (scr) check("R8 no scramble in ILA", 1, 0);
      tick();
    end
    check("R7 ILA length", ni, 128);
    check("R7 ILA flag count", nflag, 8);
    check("R7 first ILA octet flagged", int'(first_flag), 1);
    check("R8 data select", int'(sel), 3);
    check("R8 scramble flag", int'(scr), int'(se));
    check("R8 no ctrl in data", int'(ctrl_k), 0);
  endtask

  initial begin
    int sv [4] = '{0, 5, 17, 31};
    int nk;
    #1;
    check("R1 select at reset", int'(sel), 0);
    check("R1 ctrl at reset", int'(ctrl_k), 0);
    check("R1 scramble at reset", int'(scr), 0);
    tick();
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) tick();
    check("R1 idle with SYNC high", int'(sel), 0);

    sync_n = 1'b0;
    tick();
    check("R4 K28.5 after SYNC low", int'(sel), 1);
    check("R4 ctrl in CGS", int'(ctrl_k), 1);

    // R3/R5/R6 sweep over start values and all delays
    for (int si = 0; si < 4; si++)
      for (int d = 0; d < 4; d++)
        run_case(1'b1, sv[si], d, 1'((si + d) % 2), 32 - sv[si] + 32 * d);

    // R2: start value ignored without force
    run_case(1'b0, 20, 0, 1'b1, 32);
    run_case(1'b0, 9, 2, 1'b0, 96);

    // R9: realign in data state, then resync shows new alignment
    force_st = 1'b1; start_val = 5'd10; dly = 2'd0;
    sysref = 1'b1;
    tick();
    sysref = 1'b0;
    check("R9 state kept after SYSREF", int'(sel), 3);
    sync_n = 1'b0;
    tick();
    sync_n = 1'b1;
    check("R4 CGS from data", int'(sel), 1);
    nk = 0;
    while (sel == 2'b01 && nk < 1000) begin nk++; tick(); end
    check("R9 realigned K28.5 run", nk, 21);
    check("R9 ILA follows", int'(sel), 2);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule